// File: doc/BRIEF.md
# Byte-Fed Pixel Frame Serializer With Scroll-Gated Latch

This block accepts pixel command bytes from a host over a valid/ready handshake and emits them one bit at a time on a serial clock and data pair toward a chain of serial-in, serial-out LED driver devices. Every driver consumes a fixed 31-bit frame that holds the colour data for one pixel. The block cuts the byte stream into 31-bit frames. Frame boundaries do not have to line up with byte boundaries, so the offset of each frame within the byte stream moves by one bit from frame to frame.

When a frame has been fully clocked out, the block stops shifting. It then waits for a scroll tick before it raises a latch strobe. That strobe makes each driver in the chain hand its frame on to the next one, so the tick rate sets how fast the picture scrolls. No bit of the following frame is clocked before the latch, which keeps the drivers' shift registers from being overrun. A tick that arrives early is remembered in a single pending flag.

Top module: `led_frame_shifter`

## Requirements
- R1: Bits leave on `ser_data` in input order, most significant bit of each byte first. Each group of 31 consecutive bits forms one frame, wherever the byte boundaries fall.
- R2: `latch` rises only after exactly 31 rising edges of `ser_clk` since the previous latch, or since reset. `ser_clk` stays low while `latch` is high.
- R3: With no scroll tick, shifting halts after the 31st bit, even when the holding register still has bits left. No 32nd rising edge of `ser_clk` occurs before the latch.
- R4: A latch needs a tick, either present in the cycle the frame completes or recorded earlier. Any number of ticks seen before completion is stored as one pending latch, so the next frame waits for a fresh tick.
- R5: `in_ready` is low while the 8-bit holding register has unshifted bits, while a completed frame waits for its latch, and while the latch strobe is high. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R6: Each latch strobe is high for exactly LATCH_CYCLES system clocks (default 3 in the bench build).
- R7: Each high phase of `ser_clk` lasts exactly SCLK_DIV system clocks. `ser_data` changes only while `ser_clk` is low, so it is stable throughout every high phase.
- R8: `busy` is high while a frame has started but not all of its bits have been sent. It is low when no frame is in progress and when a complete frame awaits its latch.
- R9: After reset, `ser_clk`, `latch` and `busy` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| scroll_tick | input | 1 | One-cycle permission for one latch |
| ser_clk | output | 1 | Serial clock to the driver chain, idle low |
| ser_data | output | 1 | Serial data to the driver chain |
| latch | output | 1 | Frame transfer strobe to the driver chain |
| busy | output | 1 | A partly sent frame is in progress |

## Verification
The bench builds the block with FRAME_BITS 31, SCLK_DIV 2, LATCH_CYCLES 3 and most-significant-bit-first order. With a divider of 2, every bit takes four system clocks, so a frame is short enough to run eight complete frames, covering every byte-to-frame phase, in a few thousand cycles. A latch width of 3 makes an off-by-one error in the strobe length visible. The stall and pending-tick scenarios run with the same settings, and because the bench controls when ticks arrive, it can hold a finished frame for hundreds of cycles.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOW   = 3'd1,
      ST_HIGH  = 3'd2,
      ST_WAIT  = 3'd3,
      ST_LATCH = 3'd4
   } lfs_state_e;
endpackage

// File: rtl/lfs_countdown.sv
module lfs_countdown #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic done
);
   localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [CW-1:0] LOADV = CW'(LEN - 1);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("lfs_countdown: LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart)      cnt_q <= LOADV;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/lfs_byte_hold.sv
module lfs_byte_hold #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         shift,
   output logic         cur_bit,
   output logic         empty,
   output logic         last_bit
);
   localparam int NW = $clog2(W + 1);

   logic [W-1:0]  data_q;
   logic [NW-1:0] left_q;
   logic [W-1:0]  shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = data_q[W-1];
         assign shifted = {data_q[W-2:0], 1'b0};
      end else begin : g_lsb
         assign cur_bit = data_q[0];
         assign shifted = {1'b0, data_q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         left_q <= '0;
      end else if (load) begin
         data_q <= load_data;
         left_q <= NW'(W);
      end else if (shift && left_q != '0) begin
         data_q <= shifted;
         left_q <= left_q - 1'b1;
      end
   end

   assign empty    = (left_q == '0);
   assign last_bit = (left_q == NW'(1));
endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter
   import lfs_pkg::*;
#(
   parameter int FRAME_BITS   = 31,
   parameter int BYTE_W       = 8,
   parameter int SCLK_DIV     = 2,
   parameter int LATCH_CYCLES = 3,
   parameter bit MSB_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   input  logic              scroll_tick,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              latch,
   output logic              busy
);
   localparam int FCW = $clog2(FRAME_BITS + 1);
   localparam logic [FCW-1:0] LAST_IDX = FCW'(FRAME_BITS - 1);

   generate
      if (FRAME_BITS < 2)   begin : g_bad_frame $error("FRAME_BITS must be 2 or more"); end
      if (BYTE_W < 2)       begin : g_bad_byte  $error("BYTE_W must be 2 or more"); end
      if (SCLK_DIV < 1)     begin : g_bad_div   $error("SCLK_DIV must be 1 or more"); end
      if (LATCH_CYCLES < 1) begin : g_bad_lat   $error("LATCH_CYCLES must be 1 or more"); end
   endgenerate

   lfs_state_e     state_q;
   logic [FCW-1:0] fbit_q;
   logic           pend_q;

   logic hold_bit, hold_empty, hold_last;
   logic do_load, do_shift;
   logic ph_restart, ph_done;
   logic lt_restart, lt_done;
   logic latch_go;

   assign in_ready = hold_empty && (state_q != ST_WAIT) && (state_q != ST_LATCH);
   assign do_load  = in_valid && in_ready;
   assign do_shift = (state_q == ST_HIGH) && ph_done;
   assign latch_go = (state_q == ST_WAIT) && (pend_q || scroll_tick);

   assign ph_restart = ((state_q == ST_IDLE) && !hold_empty)
                     || ((state_q == ST_LOW) && ph_done)
                     || (do_shift && fbit_q != LAST_IDX && !hold_last);
   assign lt_restart = latch_go;

   lfs_byte_hold #(.W(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (do_load),
      .load_data (in_data),
      .shift     (do_shift),
      .cur_bit   (hold_bit),
      .empty     (hold_empty),
      .last_bit  (hold_last)
   );

   lfs_countdown #(.LEN(SCLK_DIV)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ph_restart),
      .done    (ph_done)
   );

   lfs_countdown #(.LEN(LATCH_CYCLES)) u_lwidth (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (lt_restart),
      .done    (lt_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fbit_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (!hold_empty) state_q <= ST_LOW;
            ST_LOW:   if (ph_done)     state_q <= ST_HIGH;
            ST_HIGH:  if (ph_done) begin
                         if (fbit_q == LAST_IDX) begin
                            fbit_q  <= fbit_q + 1'b1;
                            state_q <= ST_WAIT;
                         end else begin
                            fbit_q  <= fbit_q + 1'b1;
                            state_q <= hold_last ? ST_IDLE : ST_LOW;
                         end
                      end
            ST_WAIT:  if (latch_go)    state_q <= ST_LATCH;
            ST_LATCH: if (lt_done) begin
                         fbit_q  <= '0;
                         state_q <= ST_IDLE;
                      end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (latch_go)    pend_q <= 1'b0;
      else if (scroll_tick) pend_q <= 1'b1;
   end

   assign ser_clk  = (state_q == ST_HIGH);
   assign ser_data = hold_bit;
   assign latch    = (state_q == ST_LATCH);
   assign busy     = (state_q == ST_LOW) || (state_q == ST_HIGH)
                   || ((state_q == ST_IDLE) && fbit_q != '0);
endmodule

// File: rtl/led_frame_shifter_chk.sv
module led_frame_shifter_chk #(
   parameter int FRAME_BITS   = 31,
   parameter int LATCH_CYCLES = 3
) (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic ser_clk,
   input logic ser_data,
   input logic latch
);
   localparam int RW = $clog2(FRAME_BITS + 2) + 1;
   localparam int LW = $clog2(LATCH_CYCLES + 2) + 1;

   logic          prev_sclk, prev_latch;
   logic [RW-1:0] rise_cnt;
   logic [LW-1:0] lat_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sclk  <= 1'b0;
         prev_latch <= 1'b0;
         rise_cnt   <= '0;
         lat_w      <= '0;
      end else begin
         prev_sclk  <= ser_clk;
         prev_latch <= latch;
         if (latch && !prev_latch)        rise_cnt <= '0;
         else if (ser_clk && !prev_sclk)  rise_cnt <= rise_cnt + 1'b1;
         lat_w <= latch ? lat_w + 1'b1 : '0;
      end
   end

   p_sclk_idle_in_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> !ser_clk);
   p_full_frame_before_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !prev_latch) |-> rise_cnt == RW'(FRAME_BITS));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && !prev_sclk) |-> rise_cnt < RW'(FRAME_BITS));
   p_ready_low_in_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> !in_ready);
   p_latch_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch && prev_latch) |-> lat_w == LW'(LATCH_CYCLES));
   p_data_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && prev_sclk) |-> $stable(ser_data));
endmodule

bind led_frame_shifter led_frame_shifter_chk #(
   .FRAME_BITS  (FRAME_BITS),
   .LATCH_CYCLES(LATCH_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .ser_clk  (ser_clk),
   .ser_data (ser_data),
   .latch    (latch)
);

// File: tb/led_frame_shifter_tb.sv
module led_frame_shifter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FB   = 31;
   localparam int DIV  = 2;
   localparam int LATW = 3;
   localparam int NBYTES = 31;
   localparam int NFR    = 8;
   localparam logic [7:0] STIM [0:NBYTES-1] = '{
      8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h81, 8'h7E, 8'h55, 8'hAA,
      8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF1,
      8'h00, 8'hFF, 8'hC3, 8'h5A, 8'h69, 8'h96, 8'h01, 8'h80,
      8'hE7, 8'h18, 8'h2B, 8'hD4, 8'h47, 8'hB8, 8'h6D};

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, scroll_tick = 1'b0;
   logic [7:0] in_data = '0;
   logic in_ready, ser_clk, ser_data, latch, busy;

   int checks = 0, errors = 0;
   bit table_done = 1'b0;

   // monitor state
   logic        m_psclk, m_plat, m_pdata;
   logic [30:0] m_cur;
   int          m_rises, m_nlat, m_hi, m_viol_hi, m_viol_stab, m_lw, m_viol_lw;
   logic [30:0] m_frames [0:15];
   int          m_rise_at [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   led_frame_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .scroll_tick(scroll_tick), .ser_clk(ser_clk),
      .ser_data(ser_data), .latch(latch), .busy(busy));

   task automatic clear_mon();
      m_psclk = 0; m_plat = 0; m_pdata = 0; m_cur = '0;
      m_rises = 0; m_nlat = 0; m_hi = 0; m_viol_hi = 0; m_viol_stab = 0;
      m_lw = 0; m_viol_lw = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && !m_psclk) begin
            m_cur = {m_cur[29:0], ser_data};
            m_rises++;
         end
         if (ser_clk && m_psclk && ser_data != m_pdata) m_viol_stab++;
         if (ser_clk) m_hi++;
         else begin
            if (m_psclk && m_hi != DIV) m_viol_hi++;
            m_hi = 0;
         end
         if (latch && !m_plat) begin
            if (m_nlat < 16) begin
               m_frames[m_nlat]  = m_cur;
               m_rise_at[m_nlat] = m_rises;
            end
            m_nlat++;
            m_rises = 0;
         end
         if (latch) m_lw++;
         else begin
            if (m_plat && m_lw != LATW) m_viol_lw++;
            m_lw = 0;
         end
         m_psclk = ser_clk; m_plat = latch; m_pdata = ser_data;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; scroll_tick = 1'b0;
      repeat (3) @(negedge clk);
      clear_mon();
      rst_n = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] b);
      in_valid = 1'b1; in_data = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic tick();
      scroll_tick = 1'b1;
      @(negedge clk);
      scroll_tick = 1'b0;
   endtask

   function automatic logic [30:0] exp_frame(input int k);
      logic [30:0] f = '0;
      for (int j = 0; j < FB; j++) begin
         int i = k * FB + j;
         f = {f[29:0], STIM[i / 8][7 - (i % 8)]};
      end
      return f;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : ticker
      wait (rst_n);
      while (!table_done) begin
         repeat (150) @(negedge clk);
         if (!table_done) tick();
      end
   end

   initial begin : main
      clear_mon();
      do_reset();
      // R9 reset state
      @(negedge clk);
      check(!ser_clk && !latch && !busy && in_ready, "R9",
            {ser_clk, latch, busy, in_ready}, 4'b0001);

      // table walk: R1 frame contents across byte boundaries
      for (int n = 0; n < NBYTES; n++) send_byte(STIM[n]);
      wait (m_nlat == NFR);
      repeat (10) @(negedge clk);
      table_done = 1'b1;
      for (int k = 0; k < NFR; k++) begin
         check(m_frames[k] == exp_frame(k), "R1", m_frames[k], exp_frame(k));
         check(m_rise_at[k] == FB, "R2", m_rise_at[k], FB);
      end
      check(m_viol_lw == 0, "R6", m_viol_lw, 0);
      check(m_viol_hi == 0 && m_viol_stab == 0, "R7", m_viol_hi + m_viol_stab, 0);
      check(!busy && in_ready, "R8", {busy, in_ready}, 2'b01);
      repeat (20) @(negedge clk);

      // R3 stall: 32 bits, no tick
      do_reset();
      repeat (20) @(negedge clk);
      for (int n = 0; n < 4; n++) send_byte(8'hC9);
      repeat (400) @(negedge clk);
      check(m_rises == FB, "R3", m_rises, FB);
      check(m_nlat == 0, "R4", m_nlat, 0);
      check(!in_ready, "R5", in_ready, 0);
      check(!busy, "R8", busy, 0);
      tick();
      repeat (40) @(negedge clk);
      check(m_nlat == 1, "R4", m_nlat, 1);
      check(m_rises == 1, "R3", m_rises, 1);
      check(in_ready, "R5", in_ready, 1);
      check(busy, "R8", busy, 1);

      // R4 pending: several ticks mid-frame become one latch
      tick(); repeat (5) @(negedge clk); tick(); repeat (5) @(negedge clk); tick();
      for (int n = 0; n < 3; n++) send_byte(8'h3A);
      repeat (100) @(negedge clk);
      check(m_nlat == 1 && busy, "R4", {m_nlat[3:0], busy}, {4'd1, 1'b1});
      send_byte(8'h66);
      repeat (100) @(negedge clk);
      check(m_nlat == 2, "R4", m_nlat, 2);
      for (int n = 0; n < 4; n++) send_byte(8'h5C);
      repeat (400) @(negedge clk);
      check(m_nlat == 2, "R4", m_nlat, 2);
      check(m_rises == FB, "R3", m_rises, FB);
      tick();
      repeat (60) @(negedge clk);
      check(m_nlat == 3, "R4", m_nlat, 3);
      check(m_viol_lw == 0 && m_viol_hi == 0, "R6", m_viol_lw + m_viol_hi, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule